// File: doc/BRIEF.md
# Analog input scan controller

This block is the register-side controller for a 32-channel analog input converter, reached over an 8-bit bus with sixteen byte offsets. Software sets a low and a high channel bound, chooses between single conversions and full scans, and starts work by writing any value to offset 0. The controller then steps a channel counter from the low bound upward, wrapping from the last channel back to channel 0, and takes one conversion per channel. It stops after the high bound, or after the single low-bound channel when scanning is off.

Each result is a 16-bit two's-complement word read as two bytes. With the sample queue enabled, results collect in a 16-entry FIFO whose empty, half, full and overflow flags are visible to software. With the queue disabled, only the latest result is held. The converter itself is a behavioural stub with a fixed per-channel latency. Its data word is synthetic: the high byte is `{channel, 3'b000}` and the low byte is a conversion sequence number. The sequence number starts at 0 after reset and steps by one per conversion taken, modulo 256.

Top module: `adc_scan_ctrl`

## Requirements
- R1: The low bound (offset 2) and the high bound (offset 3) keep only bits 4:0 of the written byte. Writing 0x80 reads back 0x00, and writing 0xFF reads back 0x1F.
- R2: After reset, the following offsets read as shown:
  - offset 7 reads 0x80 (empty only);
  - offset 11 reads 0x0C;
  - offset 8 reads 0x00;
  - both bound registers read 0x00;
  - the data bytes at offsets 0 and 1 read 0x00.
- R3: The FIFO holds 16 samples. A result arriving while it is full is dropped, and the overflow flag (offset 7 bit 4) is set. The flag stays set until a FIFO reset, and the stored samples are kept.
- R4: A write of any value to offset 0 while idle starts work. Busy (offset 8 bit 7) then stays high for exactly 8 cycles per channel converted and falls after the last channel. A start write while busy is ignored and produces no extra sample.
- R5: With scan enable clear, a start takes exactly one conversion, on the low-bound channel.
- R6: With scan enable set, a start converts the channels from the low bound upward to the high bound, one sample each. The channel after 31 is 0.
- R7: A sample is read as its low byte at offset 0 and its high byte at offset 1. The sample value is `{chan[4:0], 3'b000, seq[7:0]}`, where seq counts the conversions taken since reset.
- R8: Offset 7 reads as follows:
  - bit 7 is empty;
  - bit 6 is set when 8 or more samples are held;
  - bit 5 is full;
  - bit 4 is overflow;
  - bits 3 and 2 echo the FIFO enable and scan enable.

  With FIFO enable set, a read of offset 1 removes the oldest sample. An empty FIFO reads data 0x00.
- R9: A write to offset 7 sets FIFO enable from bit 3 and scan enable from bit 2. If bit 1 is set, the same write empties the FIFO and clears overflow.
- R10: Offset 11 stores bits 5:0 of a write (scan interval, range, unipolar, gain). Its readback shows busy at bit 7 and 0 at bit 6.
- R11: Offset 8 bits 4:0 show the channel being converted. The value stays on the last converted channel after the work ends.
- R12: With FIFO enable clear, each result replaces a single held sample. Reading offsets 0 and 1 does not consume it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| busAddr | input | 4 | Byte offset of the access |
| busWrEn | input | 1 | Write strobe, one cycle per write |
| busWrData | input | 8 | Write data |
| busRdEn | input | 1 | Read strobe; a read of offset 1 with it high pops the FIFO |
| busRdData | output | 8 | Read data for busAddr, combinational |

## Verification
A wrong channel counter shows up in the high byte of the very next sample read, and in offset 8 as soon as the conversion starts. A wrong phase counter changes the busy width, which is measured to the cycle. A misdirected FIFO pointer or count shows up as a sample out of order on the first pop after the fault. It can also show up as a flag at offset 7 that disagrees with the number of samples pushed. A lost or sticky overflow appears in the flag byte read straight after the sample that should have been dropped.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;
  localparam int BUS_W    = 8;
  localparam int ADDR_W   = 4;
  localparam int SAMPLE_W = 16;

  localparam logic [ADDR_W-1:0] OFS_DATA_LO = 4'd0;
  localparam logic [ADDR_W-1:0] OFS_DATA_HI = 4'd1;
  localparam logic [ADDR_W-1:0] OFS_LO_CH   = 4'd2;
  localparam logic [ADDR_W-1:0] OFS_HI_CH   = 4'd3;
  localparam logic [ADDR_W-1:0] OFS_FIFO    = 4'd7;
  localparam logic [ADDR_W-1:0] OFS_STAT    = 4'd8;
  localparam logic [ADDR_W-1:0] OFS_CFG     = 4'd11;

  localparam logic [5:0] CFG_RESET = 6'h0C;

  typedef struct packed {
    logic push;
    logic pop;
    logic clr;
  } dpStrobe_t;
endpackage

// File: rtl/adc_conv_stub.sv
module adc_conv_stub
  import adc_scan_pkg::*;
#(
  parameter int CH_W = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                take,
  input  logic [CH_W-1:0]     chan,
  output logic [SAMPLE_W-1:0] sample
);
  logic [7:0] seq;
  logic [7:0] hiByte;

  always_ff @(posedge clk) begin
    if (!rst_n) seq <= '0;
    else if (take) seq <= seq + 8'd1;
  end

  assign hiByte = 8'({chan, 3'b000});
  assign sample = {hiByte, seq};

  p_seq_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (seq == $past(seq) + 8'd1));
endmodule

// File: rtl/adc_scan_fifo.sv
module adc_scan_fifo
  import adc_scan_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int WIDTH = SAMPLE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] pushData,
  input  logic             pop,
  input  logic             clr,
  output logic [WIDTH-1:0] headData,
  output logic             empty,
  output logic             half,
  output logic             full,
  output logic             ovf
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wrPtr, rdPtr;
  logic [CW-1:0]    count;
  logic             doPop, doPush;

  assign empty  = (count == '0);
  assign full   = (count == CW'(DEPTH));
  assign half   = (count >= CW'(DEPTH / 2));
  assign doPop  = pop && !empty;
  assign doPush = push && (!full || doPop);

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
      ovf   <= 1'b0;
    end else begin
      if (doPush) wrPtr <= (wrPtr == AW'(DEPTH - 1)) ? '0 : wrPtr + AW'(1);
      if (doPop)  rdPtr <= (rdPtr == AW'(DEPTH - 1)) ? '0 : rdPtr + AW'(1);
      if (doPush && !doPop) count <= count + CW'(1);
      else if (doPop && !doPush) count <= count - CW'(1);
      if (push && !doPush) ovf <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= pushData;
  end

  assign headData = empty ? '0 : mem[rdPtr];

  p_ovf_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !clr) |=> ovf);
  p_no_push_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop && !clr) |=> full);
  p_flags_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(full && empty));
  p_pop_count_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push && !empty && !clr) |=> !full);
endmodule

// File: rtl/adc_scan_control.sv
module adc_scan_control
  import adc_scan_pkg::*;
#(
  parameter int CH_W        = 5,
  parameter int CONV_CYCLES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [BUS_W-1:0]  busWrData,
  input  logic              busRdEn,
  output logic [CH_W-1:0]   loBound,
  output logic [CH_W-1:0]   hiBound,
  output logic [5:0]        cfgReg,
  output logic              fifoEn,
  output logic              scanEn,
  output logic              busy,
  output logic [CH_W-1:0]   curChan,
  output dpStrobe_t         strb
);
  localparam int PW = (CONV_CYCLES > 1) ? $clog2(CONV_CYCLES) : 1;

  logic [PW-1:0]   phase;
  logic [CH_W-1:0] lastChan;
  logic            startReq, chanDone;

  assign startReq = busWrEn && (busAddr == OFS_DATA_LO);
  assign chanDone = busy && (phase == PW'(CONV_CYCLES - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      loBound <= '0;
      hiBound <= '0;
      cfgReg  <= CFG_RESET;
      fifoEn  <= 1'b0;
      scanEn  <= 1'b0;
    end else if (busWrEn) begin
      case (busAddr)
        OFS_LO_CH: loBound <= busWrData[CH_W-1:0];
        OFS_HI_CH: hiBound <= busWrData[CH_W-1:0];
        OFS_FIFO: begin
          fifoEn <= busWrData[3];
          scanEn <= busWrData[2];
        end
        OFS_CFG:   cfgReg  <= busWrData[5:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      phase    <= '0;
      curChan  <= '0;
      lastChan <= '0;
    end else if (!busy) begin
      if (startReq) begin
        busy     <= 1'b1;
        phase    <= '0;
        curChan  <= loBound;
        lastChan <= scanEn ? hiBound : loBound;
      end
    end else if (chanDone) begin
      phase <= '0;
      if (curChan == lastChan) busy <= 1'b0;
      else curChan <= curChan + CH_W'(1);
    end else begin
      phase <= phase + PW'(1);
    end
  end

  always_comb begin
    strb.push = chanDone;
    strb.pop  = busRdEn && (busAddr == OFS_DATA_HI) && fifoEn;
    strb.clr  = busWrEn && (busAddr == OFS_FIFO) && busWrData[1];
  end

  p_busy_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && startReq) |=> busy);
  p_ignore_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !chanDone) |=> (busy && $stable(curChan)));
  p_single_shot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && chanDone && (curChan == lastChan)) |=> !busy);
  p_chan_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (chanDone && (curChan != lastChan)) |=> (busy && (curChan == $past(curChan) + CH_W'(1))));
  p_chan_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !startReq) |=> $stable(curChan));
endmodule

// File: rtl/adc_scan_datapath.sv
module adc_scan_datapath
  import adc_scan_pkg::*;
#(
  parameter int CH_W       = 5,
  parameter int FIFO_DEPTH = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  dpStrobe_t           strb,
  input  logic [SAMPLE_W-1:0] sample,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic [CH_W-1:0]     loBound,
  input  logic [CH_W-1:0]     hiBound,
  input  logic [5:0]          cfgReg,
  input  logic                fifoEn,
  input  logic                scanEn,
  input  logic                busy,
  input  logic [CH_W-1:0]     curChan,
  output logic [BUS_W-1:0]    busRdData
);
  logic [SAMPLE_W-1:0] holdReg, headData, viewData;
  logic                empty, half, full, ovf;

  adc_scan_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(SAMPLE_W)) i_fifo (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (strb.push && fifoEn),
    .pushData (sample),
    .pop      (strb.pop),
    .clr      (strb.clr),
    .headData (headData),
    .empty    (empty),
    .half     (half),
    .full     (full),
    .ovf      (ovf)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) holdReg <= '0;
    else if (strb.push && !fifoEn) holdReg <= sample;
  end

  assign viewData = fifoEn ? headData : holdReg;

  always_comb begin
    case (busAddr)
      OFS_DATA_LO: busRdData = viewData[7:0];
      OFS_DATA_HI: busRdData = viewData[15:8];
      OFS_LO_CH:   busRdData = BUS_W'(loBound);
      OFS_HI_CH:   busRdData = BUS_W'(hiBound);
      OFS_FIFO:    busRdData = {empty, half, full, ovf, fifoEn, scanEn, 2'b00};
      OFS_STAT:    busRdData = {busy, 2'b00, 5'(curChan)};
      OFS_CFG:     busRdData = {busy, 1'b0, cfgReg};
      default:     busRdData = '0;
    endcase
  end

  p_hold_keep_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !strb.push |=> $stable(holdReg));
endmodule

// File: rtl/adc_scan_ctrl.sv
module adc_scan_ctrl
  import adc_scan_pkg::*;
#(
  parameter int N_CHAN      = 32,
  parameter int FIFO_DEPTH  = 16,
  parameter int CONV_CYCLES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [BUS_W-1:0]  busWrData,
  input  logic              busRdEn,
  output logic [BUS_W-1:0]  busRdData
);
  localparam int CH_W = $clog2(N_CHAN);

  dpStrobe_t           strb;
  logic [CH_W-1:0]     loBound, hiBound, curChan;
  logic [5:0]          cfgReg;
  logic                fifoEn, scanEn, busy;
  logic [SAMPLE_W-1:0] sample;

  adc_scan_control #(.CH_W(CH_W), .CONV_CYCLES(CONV_CYCLES)) i_control (
    .clk       (clk),
    .rst_n     (rst_n),
    .busAddr   (busAddr),
    .busWrEn   (busWrEn),
    .busWrData (busWrData),
    .busRdEn   (busRdEn),
    .loBound   (loBound),
    .hiBound   (hiBound),
    .cfgReg    (cfgReg),
    .fifoEn    (fifoEn),
    .scanEn    (scanEn),
    .busy      (busy),
    .curChan   (curChan),
    .strb      (strb)
  );

  adc_conv_stub #(.CH_W(CH_W)) i_stub (
    .clk    (clk),
    .rst_n  (rst_n),
    .take   (strb.push),
    .chan   (curChan),
    .sample (sample)
  );

  adc_scan_datapath #(.CH_W(CH_W), .FIFO_DEPTH(FIFO_DEPTH)) i_datapath (
    .clk       (clk),
    .rst_n     (rst_n),
    .strb      (strb),
    .sample    (sample),
    .busAddr   (busAddr),
    .loBound   (loBound),
    .hiBound   (hiBound),
    .cfgReg    (cfgReg),
    .fifoEn    (fifoEn),
    .scanEn    (scanEn),
    .busy      (busy),
    .curChan   (curChan),
    .busRdData (busRdData)
  );
endmodule

// File: tb/test_adc_scan_ctrl.sv
`timescale 1ns/1ps
module test_adc_scan_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] busAddr = '0;
  logic       busWrEn = 1'b0;
  logic [7:0] busWrData = '0;
  logic       busRdEn = 1'b0;
  logic [7:0] busRdData;

  int tests = 0;
  int failed = 0;
  logic [15:0] expQ[$];
  logic [7:0]  seqMdl = 8'd0;
  int          mdlCount = 0;

  always #5 clk = ~clk;

  adc_scan_ctrl i_adc_scan_ctrl (
    .clk(clk), .rst_n(rst_n), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdEn(busRdEn), .busRdData(busRdData)
  );

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      failed++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    busAddr = a; busRdEn = 1'b1;
    #1 d = busRdData;
    @(negedge clk);
    busRdEn = 1'b0;
  endtask

  // driver: pushes expected samples, starts work, measures busy width
  task automatic runConv(input int lo, input int hi, input bit scan, input bit useFifo);
    int nch;
    int n;
    logic [7:0] v;
    nch = scan ? ((hi - lo + 32) % 32) + 1 : 1;
    for (int i = 0; i < nch; i++) begin
      logic [4:0] ch;
      ch = 5'((lo + i) % 32);
      if (useFifo) begin
        if (mdlCount < 16) begin
          expQ.push_back({ch, 3'b000, seqMdl});
          mdlCount++;
        end
      end else begin
        expQ.delete();
        expQ.push_back({ch, 3'b000, seqMdl});
      end
      seqMdl++;
    end
    wr(4'd2, 8'(lo));
    wr(4'd3, 8'(hi));
    wr(4'd0, 8'hA5);
    busAddr = 4'd8;
    #1;
    n = 0;
    while (busRdData[7]) begin
      n++;
      @(negedge clk);
      #1;
    end
    check("R4 busy width", n, nch * 8);
    rd(4'd8, v);
    check("R11 last channel", v, (lo + nch - 1) % 32);
  endtask

  // monitor: pops FIFO samples and compares with the queue
  task automatic drain();
    logic [7:0] st, l, h;
    logic [15:0] e;
    rd(4'd7, st);
    while (!st[7]) begin
      rd(4'd0, l);
      rd(4'd1, h);
      e = (expQ.size() > 0) ? expQ.pop_front() : 16'hDEAD;
      check("R7 sample", {h, l}, e);
      mdlCount--;
      rd(4'd7, st);
    end
    check("R8 queue drained", expQ.size(), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    tests++; failed++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, failed);
    $finish;
  end

  initial begin
    logic [7:0] v, v2;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R2 reset state
    rd(4'd7, v);  check("R2 fifo status", v, 8'h80);
    rd(4'd11, v); check("R2 cfg", v, 8'h0C);
    rd(4'd8, v);  check("R2 status", v, 8'h00);
    rd(4'd2, v);  check("R2 lo", v, 0);
    rd(4'd3, v);  check("R2 hi", v, 0);
    rd(4'd0, v);  check("R2 data", v, 0);
    // R1 bound masking
    wr(4'd2, 8'h80); rd(4'd2, v); check("R1 lo mask", v, 8'h00);
    wr(4'd3, 8'hFF); rd(4'd3, v); check("R1 hi mask", v, 8'h1F);
    // R5 single conversion with FIFO on, scan off
    wr(4'd7, 8'h08);
    runConv(5, 9, 1'b0, 1'b1);
    drain();
    // R6 scan upward
    wr(4'd7, 8'h0C);
    rd(4'd7, v); check("R9 enables echo", v, 8'h8C);
    runConv(3, 6, 1'b1, 1'b1);
    drain();
    // R6 wrap past 31
    runConv(30, 1, 1'b1, 1'b1);
    drain();
    // R4 start ignored while busy
    wr(4'd7, 8'h08);
    wr(4'd2, 8'd12);
    expQ.push_back({5'd12, 3'b000, seqMdl}); seqMdl++; mdlCount++;
    wr(4'd0, 8'h01);
    wr(4'd0, 8'h02);
    rd(4'd11, v); check("R10 wait bit during busy", v, 8'h8C);
    repeat (12) @(negedge clk);
    drain();
    // R10 config store
    wr(4'd11, 8'hFF); rd(4'd11, v); check("R10 cfg store", v, 8'h3F);
    // R8 / R3 half, full, overflow
    wr(4'd7, 8'h0C);
    runConv(0, 7, 1'b1, 1'b1);
    rd(4'd7, v); check("R8 half", v, 8'h4C);
    runConv(8, 15, 1'b1, 1'b1);
    rd(4'd7, v); check("R8 full", v, 8'h6C);
    runConv(20, 20, 1'b1, 1'b1);
    rd(4'd7, v); check("R3 overflow set", v, 8'h7C);
    drain();
    rd(4'd7, v); check("R3 overflow sticky", v, 8'h9C);
    wr(4'd7, 8'h0E);
    rd(4'd7, v); check("R9 fifo reset", v, 8'h8C);
    // R9 reset clears stored samples
    runConv(2, 3, 1'b1, 1'b1);
    wr(4'd7, 8'h0E); expQ.delete(); mdlCount = 0;
    rd(4'd7, v); check("R9 reset empties", v, 8'h8C);
    // R12 hold register, no consumption
    wr(4'd7, 8'h00);
    runConv(7, 7, 1'b0, 1'b0);
    rd(4'd0, v); rd(4'd1, v2);
    check("R12 hold sample", {v2, v}, expQ[0]);
    rd(4'd1, v2); rd(4'd0, v);
    check("R12 reread", {v2, v}, expQ[0]);
    runConv(9, 9, 1'b0, 1'b0);
    rd(4'd0, v); rd(4'd1, v2);
    check("R12 replace", {v2, v}, expQ[0]);
    $display("[TB] %0d tests run, %0d failed", tests, failed);
    $finish;
  end
endmodule